// File: doc/BRIEF.md
# Command address auto-update unit

This unit holds the command address of one sub-sequence of a memory-training command engine: a 16-bit row/column field, a 3-bit bank and a 2-bit rank. A load strobe sets the starting address and the seed of a 23-bit scrambling LFSR. Each command-issued pulse counts toward an update, and when the programmed number of command runs has passed, the stored address is stepped and written back.

The row/column step adds 1, 8 or both. It is confined to a window of low bits chosen by a wrap index, and the bits above that window keep their loaded value. Bank and rank advance by their own programmed steps. An optional scrambling mode then XORs LFSR bits into the window, or into the window without its three lowest bits, and advances the LFSR. On deselect cycles, where no command is issued, the LFSR can mask the driven address, with or without a step. The live LFSR state is visible at all times for read-back.

Top module: `cmd_addr_updater`

## Requirements
- R1: After reset the stored row/column, bank and rank are all zero and the LFSR state reads all ones.
- R2: When load_i is high at a clock edge, the stored address takes the load values, the LFSR takes the seed (a zero seed becomes all ones) and the update counter restarts. A load takes priority over a command in the same cycle.
- R3: On an update the row/column adds 1 when inc_one_i is set, adds 8 when inc_eight_i is set, or adds 9 when both are set. The sum wraps inside bits [w..0], where w is wrap_idx_i (a value of 15 or more covers all 16 bits). Bits above w keep their value.
- R4: On an update the bank adds bank_step_i modulo 8, and the rank adds rank_step_i (0 to 3) modulo 4.
- R5: With rate_i = N, an update happens on the (N+1)-th command after a load or after the previous update. Commands that do not cause an update leave the address and the LFSR unchanged.
- R6: scramble_mode_i = 2 XORs lfsr_o[15:0] into the window bits after the step. A value of 3 does the same but leaves bits [2:0] unscrambled. In both modes the LFSR then advances one step. Values 0 and 1 neither scramble nor advance.
- R7: One LFSR step shifts the state left by one bit and sets the new bit 0 to the XOR of state bits 22 and 17. The state is never zero.
- R8: On a cycle with desel_i high, and cmd_i and load_i low, idle_mode_i = 1 drives drv_rowcol_o = rowcol_o ^ lfsr_o[15:0] and drv_bank_o = bank_o ^ lfsr_o[18:16] without advancing the LFSR. Mode 2 drives the same values and advances the LFSR once. Modes 0 and 3 drive the stored address and leave the LFSR alone. In all other cycles the drive outputs equal the stored address.
- R9: In a cycle with neither load_i nor cmd_i high, the stored address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load start address and seed |
| ld_rowcol_i | input | 16 | Start row/column |
| ld_bank_i | input | 3 | Start bank |
| ld_rank_i | input | 2 | Start rank |
| ld_seed_i | input | 23 | LFSR seed |
| inc_one_i | input | 1 | Row/column step of 1 |
| inc_eight_i | input | 1 | Row/column step of 8 |
| bank_step_i | input | 1 | Bank step of 1 |
| rank_step_i | input | 2 | Rank step |
| wrap_idx_i | input | 5 | Top bit of the wrap window |
| scramble_mode_i | input | 2 | LFSR scrambling on updates |
| rate_i | input | 4 | Command runs skipped between updates |
| idle_mode_i | input | 2 | LFSR behaviour on deselect cycles |
| cmd_i | input | 1 | Command issued this cycle |
| desel_i | input | 1 | Deselect cycle |
| rowcol_o | output | 16 | Stored row/column |
| bank_o | output | 3 | Stored bank |
| rank_o | output | 2 | Stored rank |
| lfsr_o | output | 23 | LFSR state |
| drv_rowcol_o | output | 16 | Row/column as driven this cycle |
| drv_bank_o | output | 3 | Bank as driven this cycle |

## Verification
The assertions assume that the configuration inputs stay constant between a load and the commands that follow it. They also assume that deselect pulses matter only when no command or load is present. The stimulus changes configuration only in cycles before a new load and keeps commands and loads on separate cycles, except in the one check of load priority. The sweeps cover every wrap index, every step combination, rates 0 to 5 and all scramble and idle modes, with expected values computed in the bench from the requirements.

// File: rtl/cau_pkg.sv
package cau_pkg;
  typedef enum logic [1:0] {
    SCR_OFF   = 2'd0,
    SCR_RSVD  = 2'd1,
    SCR_FULL  = 2'd2,
    SCR_SKIP3 = 2'd3
  } scr_mode_e;

  typedef enum logic [1:0] {
    IDLE_HOLD      = 2'd0,
    IDLE_MASK      = 2'd1,
    IDLE_MASK_STEP = 2'd2,
    IDLE_RSVD      = 2'd3
  } idle_mode_e;
endpackage

// File: rtl/cau_lfsr.sv
module cau_lfsr #(
  parameter int unsigned W     = 23,
  parameter int unsigned TAP_A = 23,
  parameter int unsigned TAP_B = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, state_d;
  logic         fb;

  assign fb = state_q[TAP_A-1] ^ state_q[TAP_B-1];

  always_comb begin
    state_d = state_q;
    if (load_i)      state_d = (seed_i == '0) ? '1 : seed_i;
    else if (step_i) state_d = {state_q[W-2:0], fb};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '1;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

  // R7
  lfsr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (state_o[W-1:1] == $past(state_o[W-2:0])));
endmodule

// File: rtl/cau_rate_div.sv
module cau_rate_div #(
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              cmd_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              fire_o
);
  logic [RATE_W-1:0] cnt_q;

  // >= keeps the counter bounded if the rate is lowered mid-run
  assign fire_o = cmd_i && !load_i && (cnt_q >= rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= '0;
    else if (cmd_i)  cnt_q <= fire_o ? '0 : cnt_q + 1'b1;
  end

  // R5
  rate_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i && !load_i && rate_i == '0) |-> fire_o);

  // R5
  no_cmd_no_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i |-> !fire_o);
endmodule

// File: rtl/cau_addr_next.sv
module cau_addr_next
  import cau_pkg::*;
#(
  parameter int unsigned RC_W   = 16,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned RANK_W = 2
) (
  input  logic [RC_W-1:0]   cur_rowcol_i,
  input  logic [BANK_W-1:0] cur_bank_i,
  input  logic [RANK_W-1:0] cur_rank_i,
  input  logic [RC_W-1:0]   win_mask_i,
  input  logic              inc_one_i,
  input  logic              inc_eight_i,
  input  logic              bank_step_i,
  input  logic [RANK_W-1:0] rank_step_i,
  input  logic [1:0]        scr_mode_i,
  input  logic [RC_W-1:0]   lfsr_bits_i,
  output logic [RC_W-1:0]   nxt_rowcol_o,
  output logic [BANK_W-1:0] nxt_bank_o,
  output logic [RANK_W-1:0] nxt_rank_o,
  output logic              scr_on_o
);
  logic [RC_W-1:0] delta, summed, stepped, scr_mask;

  assign scr_on_o = (scr_mode_i == SCR_FULL) || (scr_mode_i == SCR_SKIP3);

  always_comb begin
    delta    = (inc_eight_i ? RC_W'(8) : '0) + (inc_one_i ? RC_W'(1) : '0);
    summed   = cur_rowcol_i + delta;
    stepped  = (cur_rowcol_i & ~win_mask_i) | (summed & win_mask_i);
    scr_mask = win_mask_i & ((scr_mode_i == SCR_SKIP3) ? ~RC_W'(7) : '1);
    nxt_rowcol_o = scr_on_o ? (stepped ^ (lfsr_bits_i & scr_mask)) : stepped;
  end

  assign nxt_bank_o = cur_bank_i + BANK_W'(bank_step_i);
  assign nxt_rank_o = cur_rank_i + rank_step_i;
endmodule

// File: rtl/cmd_addr_updater.sv
module cmd_addr_updater
  import cau_pkg::*;
#(
  parameter int unsigned RC_W   = 16,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned RANK_W = 2,
  parameter int unsigned LFSR_W = 23,
  parameter int unsigned WRAP_W = 5,
  parameter int unsigned RATE_W = 4,
  parameter int unsigned TAP_A  = 23,
  parameter int unsigned TAP_B  = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [RC_W-1:0]   ld_rowcol_i,
  input  logic [BANK_W-1:0] ld_bank_i,
  input  logic [RANK_W-1:0] ld_rank_i,
  input  logic [LFSR_W-1:0] ld_seed_i,
  input  logic              inc_one_i,
  input  logic              inc_eight_i,
  input  logic              bank_step_i,
  input  logic [RANK_W-1:0] rank_step_i,
  input  logic [WRAP_W-1:0] wrap_idx_i,
  input  logic [1:0]        scramble_mode_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [1:0]        idle_mode_i,
  input  logic              cmd_i,
  input  logic              desel_i,
  output logic [RC_W-1:0]   rowcol_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [RANK_W-1:0] rank_o,
  output logic [LFSR_W-1:0] lfsr_o,
  output logic [RC_W-1:0]   drv_rowcol_o,
  output logic [BANK_W-1:0] drv_bank_o
);
  localparam int unsigned MASK_LSB = RC_W;
  localparam int unsigned MASK_MSB = RC_W + BANK_W - 1;

  logic [RC_W-1:0]   rowcol_q, nxt_rowcol;
  logic [BANK_W-1:0] bank_q, nxt_bank;
  logic [RANK_W-1:0] rank_q, nxt_rank;
  logic [RC_W-1:0]   win_mask;
  logic [LFSR_W-1:0] lfsr_state;
  logic              fire, scr_on, idle_cyc, idle_mask, lfsr_step;

  for (genvar b = 0; b < RC_W; b++) begin : g_win
    assign win_mask[b] = (32'(wrap_idx_i) >= 32'(b));
  end

  cau_rate_div #(.RATE_W(RATE_W)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .cmd_i  (cmd_i),
    .rate_i (rate_i),
    .fire_o (fire)
  );

  cau_addr_next #(.RC_W(RC_W), .BANK_W(BANK_W), .RANK_W(RANK_W)) u_next (
    .cur_rowcol_i (rowcol_q),
    .cur_bank_i   (bank_q),
    .cur_rank_i   (rank_q),
    .win_mask_i   (win_mask),
    .inc_one_i    (inc_one_i),
    .inc_eight_i  (inc_eight_i),
    .bank_step_i  (bank_step_i),
    .rank_step_i  (rank_step_i),
    .scr_mode_i   (scramble_mode_i),
    .lfsr_bits_i  (lfsr_state[RC_W-1:0]),
    .nxt_rowcol_o (nxt_rowcol),
    .nxt_bank_o   (nxt_bank),
    .nxt_rank_o   (nxt_rank),
    .scr_on_o     (scr_on)
  );

  assign idle_cyc  = desel_i && !cmd_i && !load_i;
  assign idle_mask = idle_cyc &&
                     (idle_mode_i == IDLE_MASK || idle_mode_i == IDLE_MASK_STEP);
  assign lfsr_step = (fire && scr_on) || (idle_cyc && idle_mode_i == IDLE_MASK_STEP);

  cau_lfsr #(.W(LFSR_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .seed_i  (ld_seed_i),
    .step_i  (lfsr_step),
    .state_o (lfsr_state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rowcol_q <= '0;
      bank_q   <= '0;
      rank_q   <= '0;
    end else if (load_i) begin
      rowcol_q <= ld_rowcol_i;
      bank_q   <= ld_bank_i;
      rank_q   <= ld_rank_i;
    end else if (fire) begin
      rowcol_q <= nxt_rowcol;
      bank_q   <= nxt_bank;
      rank_q   <= nxt_rank;
    end
  end

  assign rowcol_o     = rowcol_q;
  assign bank_o       = bank_q;
  assign rank_o       = rank_q;
  assign lfsr_o       = lfsr_state;
  assign drv_rowcol_o = rowcol_q ^ (idle_mask ? lfsr_state[RC_W-1:0] : '0);
  assign drv_bank_o   = bank_q ^ (idle_mask ? lfsr_state[MASK_MSB:MASK_LSB] : '0);

  // R2
  load_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (rowcol_o == $past(ld_rowcol_i) && bank_o == $past(ld_bank_i) &&
                rank_o == $past(ld_rank_i)));

  // R9
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !cmd_i) |=> ($stable(rowcol_o) && $stable(bank_o) && $stable(rank_o)));

  // R3
  above_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i && !load_i) |=> (((rowcol_o ^ $past(rowcol_o)) & ~$past(win_mask)) == '0));

  // R8
  idle_lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_cyc && idle_mode_i != IDLE_MASK_STEP) |=> $stable(lfsr_o));

  // R8
  drv_plain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !desel_i |-> (drv_rowcol_o == rowcol_o && drv_bank_o == bank_o));
endmodule

// File: tb/cmd_addr_updater_tb.sv
module cmd_addr_updater_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] ld_rowcol_i = '0;
  logic [2:0]  ld_bank_i = '0;
  logic [1:0]  ld_rank_i = '0;
  logic [22:0] ld_seed_i = '0;
  logic        inc_one_i = 1'b0, inc_eight_i = 1'b0, bank_step_i = 1'b0;
  logic [1:0]  rank_step_i = '0;
  logic [4:0]  wrap_idx_i = 5'd15;
  logic [1:0]  scramble_mode_i = '0;
  logic [3:0]  rate_i = '0;
  logic [1:0]  idle_mode_i = '0;
  logic        cmd_i = 1'b0, desel_i = 1'b0;
  logic [15:0] rowcol_o, drv_rowcol_o;
  logic [2:0]  bank_o, drv_bank_o;
  logic [1:0]  rank_o;
  logic [22:0] lfsr_o;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_rc;
  logic [2:0]  m_bank;
  logic [1:0]  m_rank;
  logic [22:0] m_lfsr;
  int          m_cnt;

  always #5 clk_i = ~clk_i;

  cmd_addr_updater u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [22:0] lstep(input logic [22:0] s);
    return {s[21:0], s[22] ^ s[17]};
  endfunction

  function automatic logic [15:0] wmask(input logic [4:0] w);
    logic [15:0] m;
    for (int b = 0; b < 16; b++) m[b] = (int'(w) >= b);
    return m;
  endfunction

  task automatic model(input bit c, d, l);
    logic [15:0] msk, sum, smsk;
    if (l) begin
      m_rc = ld_rowcol_i; m_bank = ld_bank_i; m_rank = ld_rank_i;
      m_lfsr = (ld_seed_i == 0) ? '1 : ld_seed_i; m_cnt = 0;
    end else if (c) begin
      if (m_cnt >= int'(rate_i)) begin
        m_cnt = 0;
        msk = wmask(wrap_idx_i);
        sum = m_rc + (inc_one_i ? 16'd1 : 16'd0) + (inc_eight_i ? 16'd8 : 16'd0);
        m_rc = (m_rc & ~msk) | (sum & msk);
        if (scramble_mode_i[1]) begin
          smsk = msk & ((scramble_mode_i == 2'd3) ? 16'hFFF8 : 16'hFFFF);
          m_rc = m_rc ^ (m_lfsr[15:0] & smsk);
          m_lfsr = lstep(m_lfsr);
        end
        m_bank = m_bank + 3'(bank_step_i);
        m_rank = m_rank + rank_step_i;
      end else m_cnt++;
    end else if (d && idle_mode_i == 2'd2) m_lfsr = lstep(m_lfsr);
  endtask

  // one cycle, entered and left at a falling edge
  task automatic cyc(input bit c, d, l, input string req);
    logic [15:0] er;
    logic [2:0]  eb;
    bit msk_on;
    cmd_i = c; desel_i = d; load_i = l;
    #1;
    msk_on = d && !c && !l && (idle_mode_i == 2'd1 || idle_mode_i == 2'd2);
    er = msk_on ? m_rc ^ m_lfsr[15:0] : m_rc;
    eb = msk_on ? m_bank ^ m_lfsr[18:16] : m_bank;
    if (d) begin
      chk(drv_rowcol_o == er, "R8 drv_rowcol", 32'(drv_rowcol_o), 32'(er));
      chk(drv_bank_o == eb, "R8 drv_bank", 32'(drv_bank_o), 32'(eb));
    end
    model(c, d, l);
    @(negedge clk_i);
    cmd_i = 0; desel_i = 0; load_i = 0;
    chk(rowcol_o == m_rc, {req, " rowcol"}, 32'(rowcol_o), 32'(m_rc));
    chk(bank_o == m_bank, {req, " bank"}, 32'(bank_o), 32'(m_bank));
    chk(rank_o == m_rank, {req, " rank"}, 32'(rank_o), 32'(m_rank));
    chk(lfsr_o == m_lfsr, {req, " lfsr"}, 32'(lfsr_o), 32'(m_lfsr));
  endtask

  task automatic ld(input logic [15:0] rc, input logic [2:0] bk, input logic [1:0] rk,
                    input logic [22:0] sd);
    ld_rowcol_i = rc; ld_bank_i = bk; ld_rank_i = rk; ld_seed_i = sd;
    cyc(0, 0, 1, "R2");
  endtask

  task automatic cfg(input bit i1, i8, bs, input logic [1:0] rs, input logic [4:0] w,
                     input logic [1:0] sm, input logic [3:0] rt, input logic [1:0] im);
    inc_one_i = i1; inc_eight_i = i8; bank_step_i = bs; rank_step_i = rs;
    wrap_idx_i = w; scramble_mode_i = sm; rate_i = rt; idle_mode_i = im;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_rc = '0; m_bank = '0; m_rank = '0; m_lfsr = '1; m_cnt = 0;
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(rowcol_o == 16'h0 && bank_o == 3'h0 && rank_o == 2'h0, "R1 addr",
        {11'h0, rank_o, bank_o, rowcol_o}, 32'h0);
    chk(lfsr_o == 23'h7FFFFF, "R1 lfsr", 32'(lfsr_o), 32'h7FFFFF);

    // R2 load and zero seed
    ld(16'hBEEF, 3'd6, 2'd2, 23'h12345);
    ld(16'h0F0F, 3'd1, 2'd1, 23'h0);

    // R3 wrap sweep for steps 1, 8 and 9
    for (int st = 1; st <= 3; st++)
      for (int w = 0; w <= 17; w++) begin
        cfg(st[0], st[1], 0, 2'd0, 5'(w), 2'd0, 4'd0, 2'd0);
        ld(16'hA5F7, 3'd0, 2'd0, 23'h1);
        for (int k = 0; k < 4; k++) cyc(1, 0, 0, "R3");
      end

    // R4 bank and rank steps
    for (int rs = 0; rs < 4; rs++)
      for (int bs = 0; bs < 2; bs++) begin
        cfg(0, 0, bs[0], 2'(rs), 5'd15, 2'd0, 4'd0, 2'd0);
        ld(16'h0, 3'd5, 2'd3, 23'h1);
        for (int k = 0; k < 9; k++) cyc(1, 0, 0, "R4");
      end

    // R5 update rate
    for (int rt = 0; rt <= 5; rt++) begin
      cfg(1, 0, 1, 2'd1, 5'd15, 2'd2, 4'(rt), 2'd0);
      ld(16'h0010, 3'd0, 2'd0, 23'h2AAAA);
      for (int k = 0; k < 13; k++) cyc(1, 0, 0, "R5");
    end

    // R6 R7 scrambling modes
    for (int sm = 0; sm < 4; sm++)
      for (int w = 3; w <= 15; w += 4) begin
        cfg(1, 1, 0, 2'd0, 5'(w), 2'(sm), 4'd0, 2'd0);
        ld(16'h8421, 3'd0, 2'd0, 23'h5A5A5);
        for (int k = 0; k < 24; k++) cyc(1, 0, 0, "R6");
      end

    // R8 deselect behaviour, including command priority over deselect
    for (int im = 0; im < 4; im++) begin
      cfg(1, 0, 1, 2'd1, 5'd15, 2'd0, 4'd0, 2'(im));
      ld(16'h1234, 3'd5, 2'd0, 23'h3C3C3);
      for (int k = 0; k < 5; k++) cyc(0, 1, 0, "R8");
      cyc(1, 1, 0, "R8");
      cyc(0, 1, 0, "R8");
    end

    // R2 load wins over command, counter restarts
    cfg(1, 0, 0, 2'd0, 5'd15, 2'd0, 4'd1, 2'd0);
    ld(16'h0100, 3'd0, 2'd0, 23'h1);
    cyc(1, 0, 0, "R2");
    ld_rowcol_i = 16'h0200;
    cyc(1, 0, 1, "R2");
    cyc(1, 0, 0, "R2");
    cyc(1, 0, 0, "R2");

    // R9 no command, no load: load values and config change, state holds
    ld_rowcol_i = 16'hFFFF; ld_bank_i = 3'd7; ld_seed_i = 23'h777;
    cfg(1, 1, 1, 2'd3, 5'd2, 2'd2, 4'd0, 2'd0);
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, "R9");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule